// File: doc/BRIEF.md
# Programmable Baud-Rate Tick Generator

This block turns a fixed reference clock into the sampling enable for one serial channel. It issues a one-cycle pulse at sixteen times the baud rate. The rate is set by a 16-bit divisor, which is stored as two byte registers: a low byte and a high byte. Software can write or read these registers only while the access-select bit from the line-control logic is high. When that bit is low, writes are dropped and the readback shows zero.

A mode input inserts a fixed divide-by-four prescale ahead of the divider. The tick rate is therefore f_ref / (divisor × prescale), and the baud rate is that tick rate divided by 16. Writing either divisor byte reloads the down-counter and restarts the prescale phase at once, so a new rate takes effect without first running out a long stale count. A divisor of zero stops the generator.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset, both divisor bytes read back as 0 and `tick_o` is low.
- R2: While `dl_access_i` is 1, a write with `wr_en_i` = 1 stores `wr_data_i` into the low byte when `wr_hi_i` = 0 and into the high byte when `wr_hi_i` = 1. The new value appears on `div_lo_o` / `div_hi_o` one cycle later.
- R3: While `dl_access_i` is 0, writes leave both bytes unchanged, and `div_lo_o` and `div_hi_o` both read 0.
- R4: A write that is accepted reloads the counter. With divisor D and prescale P, the first tick appears on the output sampled D×P clock edges after the write edge.
- R5: With `prescale_sel_i` = 0, ticks repeat every D reference cycles.
- R6: With `prescale_sel_i` = 1, ticks repeat every 4×D reference cycles.
- R7: With a divisor of 0, no tick is produced.
- R8: With a divisor of 1 and `prescale_sel_i` = 0, `tick_o` is high on every cycle.
- R9: When D×P > 1, each tick is exactly one clock wide.
- R10: The largest divisor, 65535, works: the first tick comes 65535 cycles after the reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dl_access_i | input | 1 | Divisor access select (bit 7 of line control) |
| prescale_sel_i | input | 1 | 1 selects the extra divide-by-4 prescale |
| wr_en_i | input | 1 | Divisor byte write strobe |
| wr_hi_i | input | 1 | Byte select: 0 low, 1 high |
| wr_data_i | input | 8 | Byte to store |
| div_lo_o | output | 8 | Low divisor byte readback (0 when access is off) |
| div_hi_o | output | 8 | High divisor byte readback (0 when access is off) |
| tick_o | output | 1 | One-cycle pulse at 16× the baud rate |

## Verification
The single-width tick property assumes that the prescale mode does not change while a divisor of 1 is loaded. It also assumes that no write arrives in the cycle after a tick. The bench changes `prescale_sel_i` only before it loads a new divisor, and it writes only in idle gaps. All inputs are driven on the falling edge, so every write is a single clean strobe that either the access bit admits or it does not.

// File: rtl/baudgen_pkg.sv
package baudgen_pkg;
    // Which divisor byte a write targets.
    typedef enum logic {
        SEL_LO = 1'b0,
        SEL_HI = 1'b1
    } byte_sel_e;

    // Number of bytes that make up the divisor.
    localparam int DIV_BYTES = 2;
endpackage

// File: rtl/bdg_div_regs.sv
// bdg_div_regs: holds the divisor as separate byte registers.
// A write is accepted only while the access bit is high. In the same
// cycle, the module drives the post-write divisor value and a reload
// strobe for the counter.
// Assumes: at most one byte is written per cycle.
module bdg_div_regs
    import baudgen_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int DIV_W = BYTE_W * DIV_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              access_i,
    input  logic              wr_en_i,
    input  logic              wr_hi_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    output logic [DIV_W-1:0]  div_o,
    output logic [DIV_W-1:0]  next_div_o,
    output logic              reload_o
);
    logic wr_ok;

    // Accept a write only while the divisor registers are mapped in.
    always_comb wr_ok = wr_en_i & access_i;

    assign reload_o = wr_ok;

    for (genvar g = 0; g < DIV_BYTES; g++) begin : g_byte
        localparam byte_sel_e SEL = (g == 0) ? SEL_LO : SEL_HI;
        logic [BYTE_W-1:0] q;
        logic              hit;

        // This byte is the target of the current write.
        always_comb hit = wr_ok & (byte_sel_e'(wr_hi_i) == SEL);

        // Store the byte on an accepted write to this lane.
        always_ff @(posedge clk) begin
            if (!rst_n)   q <= '0;
            else if (hit) q <= wr_data_i;
        end

        assign div_o[g*BYTE_W +: BYTE_W]      = q;
        assign next_div_o[g*BYTE_W +: BYTE_W] = hit ? wr_data_i : q;
    end
endmodule

// File: rtl/bdg_prescale.sv
// bdg_prescale: optional divide-by-2^PRE_W enable ahead of the divider.
// When sel_i is 0 the enable is high every cycle. When sel_i is 1 it
// is high once per 2^PRE_W cycles. clear_i restarts the phase.
// Assumes: clear_i is a single-cycle strobe.
module bdg_prescale #(
    parameter int PRE_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic sel_i,
    output logic en_o
);
    logic [PRE_W-1:0] phase_q;

    // Free-running phase counter, restarted by a reload.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) phase_q <= '0;
        else                   phase_q <= phase_q + 1'b1;
    end

    // Issue an enable each cycle, or only on the last phase slot.
    always_comb en_o = sel_i ? (&phase_q) : 1'b1;
endmodule

// File: rtl/bdg_divider.sv
// bdg_divider: down-counter that emits a registered tick when it hits 1,
// then reloads from the divisor.
// A load restarts the count from load_val_i. A divisor of 0 holds the
// counter and emits nothing.
// Assumes: div_i is the currently stored divisor.
module bdg_divider #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic [CNT_W-1:0] div_i,
    input  logic             en_i,
    output logic             tick_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             tick_q;
    logic             run;
    logic             expire;

    // Count only when enabled and a nonzero divisor is present.
    always_comb run = en_i & (div_i != '0);

    // Terminal state; a stale 0 also counts as expired.
    always_comb expire = (cnt_q <= CNT_W'(1));

    // Counter: load on a write, reload on expiry, otherwise decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (load_i) cnt_q <= load_val_i;
        else if (run)    cnt_q <= expire ? div_i : cnt_q - 1'b1;
    end

    // Registered tick, one cycle per expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || load_i) tick_q <= 1'b0;
        else                  tick_q <= run & expire;
    end

    assign tick_o = tick_q;
endmodule

// File: rtl/baud_tick_gen.sv
// baud_tick_gen: top of the baud-rate tick generator.
// Wires together the divisor registers, the optional prescale and the
// down-counter. Readback is gated by the access bit.
// Assumes: synchronous active-low reset; clk is the reference clock.
module baud_tick_gen
    import baudgen_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int PRE_W  = 2,
    localparam int DIV_W = BYTE_W * DIV_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dl_access_i,
    input  logic              prescale_sel_i,
    input  logic              wr_en_i,
    input  logic              wr_hi_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    output logic [BYTE_W-1:0] div_lo_o,
    output logic [BYTE_W-1:0] div_hi_o,
    output logic              tick_o
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] next_div;
    logic             reload;
    logic             pre_en;

    bdg_div_regs #(.BYTE_W(BYTE_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .access_i   (dl_access_i),
        .wr_en_i    (wr_en_i),
        .wr_hi_i    (wr_hi_i),
        .wr_data_i  (wr_data_i),
        .div_o      (div_q),
        .next_div_o (next_div),
        .reload_o   (reload)
    );

    bdg_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (reload),
        .sel_i   (prescale_sel_i),
        .en_o    (pre_en)
    );

    bdg_divider #(.CNT_W(DIV_W)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (reload),
        .load_val_i (next_div),
        .div_i      (div_q),
        .en_i       (pre_en),
        .tick_o     (tick_o)
    );

    // Readback shows the stored bytes only while access is granted.
    always_comb begin
        div_lo_o = dl_access_i ? div_q[BYTE_W-1:0]      : '0;
        div_hi_o = dl_access_i ? div_q[DIV_W-1:BYTE_W]  : '0;
    end
endmodule

// File: rtl/baud_tick_gen_chk.sv
// baud_tick_gen_chk: property checker bound into baud_tick_gen.
// Assumes: no write in the cycle after a tick; the prescale mode is
// not changed while a divisor of 1 is loaded.
module baud_tick_gen_chk #(
    parameter int BYTE_W = 8,
    localparam int DIV_W = 2 * BYTE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dl_access_i,
    input logic              wr_en_i,
    input logic              wr_hi_i,
    input logic [BYTE_W-1:0] wr_data_i,
    input logic [BYTE_W-1:0] div_lo_o,
    input logic [BYTE_W-1:0] div_hi_o,
    input logic [DIV_W-1:0]  div_q,
    input logic              tick_o
);
    logic was_in_reset = 1'b0;

    // Track a reset edge so the reset state is checked one cycle later.
    always_ff @(posedge clk) begin
        was_in_reset <= !rst_n;
        if (was_in_reset) begin
            assert_reset_state_R1: assert (!tick_o && div_q == '0)
                else $error("R1 reset state wrong");
        end
    end

    assert_write_lo_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && dl_access_i && !wr_hi_i) |=> div_q[BYTE_W-1:0] == $past(wr_data_i));

    assert_write_hi_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && dl_access_i && wr_hi_i) |=> div_q[DIV_W-1:BYTE_W] == $past(wr_data_i));

    assert_locked_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!dl_access_i) |=> $stable(div_q));

    assert_locked_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!dl_access_i) |-> (div_lo_o == '0 && div_hi_o == '0));

    assert_write_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && dl_access_i) |=> !tick_o);

    assert_zero_stopped_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q == '0 && !(wr_en_i && dl_access_i)) |=> !tick_o);

    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && div_q > DIV_W'(1) && !(wr_en_i && dl_access_i)) |=> !tick_o);
endmodule

bind baud_tick_gen baud_tick_gen_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dl_access_i (dl_access_i),
    .wr_en_i     (wr_en_i),
    .wr_hi_i     (wr_hi_i),
    .wr_data_i   (wr_data_i),
    .div_lo_o    (div_lo_o),
    .div_hi_o    (div_hi_o),
    .div_q       (div_q),
    .tick_o      (tick_o)
);

// File: tb/baud_tick_gen_tb.sv
// baud_tick_gen_tb: directed scenarios, one task each, self-checking.
module baud_tick_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dl_access_i = 1'b0;
    logic       prescale_sel_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic       wr_hi_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic [7:0] div_lo_o;
    logic [7:0] div_hi_o;
    logic       tick_o;

    int checks = 0;
    int errors = 0;

    baud_tick_gen u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .dl_access_i    (dl_access_i),
        .prescale_sel_i (prescale_sel_i),
        .wr_en_i        (wr_en_i),
        .wr_hi_i        (wr_hi_i),
        .wr_data_i      (wr_data_i),
        .div_lo_o       (div_lo_o),
        .div_hi_o       (div_hi_o),
        .tick_o         (tick_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Record one check and report it if it failed.
    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    // One write strobe, driven on the falling edge; returns after the
    // falling edge that follows the write edge.
    task automatic wr_byte(input logic hi, input logic [7:0] data);
        @(negedge clk);
        wr_en_i = 1'b1;
        wr_hi_i = hi;
        wr_data_i = data;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    // Load a 16-bit divisor; the reload point is the high-byte write.
    task automatic set_div(input int d);
        dl_access_i = 1'b1;
        wr_byte(1'b0, d[7:0]);
        wr_byte(1'b1, d[15:8]);
    endtask

    // Count edges until the next sampled tick; returns 0 if none seen.
    task automatic find_tick(input int limit, output int n);
        n = 0;
        for (int k = 1; k <= limit; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (tick_o) begin
                n = k;
                return;
            end
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        dl_access_i = 1'b1;
        @(negedge clk);
        check("R1 lo", div_lo_o, 0);
        check("R1 hi", div_hi_o, 0);
        check("R1 tick", tick_o, 0);
    endtask

    task automatic t_write_read();
        dl_access_i = 1'b1;
        wr_byte(1'b0, 8'h34);
        check("R2 lo", div_lo_o, 8'h34);
        wr_byte(1'b1, 8'h12);
        check("R2 hi", div_hi_o, 8'h12);
        check("R2 lo kept", div_lo_o, 8'h34);
    endtask

    task automatic t_locked();
        dl_access_i = 1'b0;
        wr_byte(1'b0, 8'hFF);
        wr_byte(1'b1, 8'hEE);
        check("R3 read lo gated", div_lo_o, 0);
        check("R3 read hi gated", div_hi_o, 0);
        @(negedge clk);
        dl_access_i = 1'b1;
        #1;
        check("R3 lo unchanged", div_lo_o, 8'h34);
        check("R3 hi unchanged", div_hi_o, 8'h12);
    endtask

    task automatic t_period5();
        int n;
        prescale_sel_i = 1'b0;
        set_div(5);
        find_tick(100, n);
        check("R4 first tick D=5", n, 5);
        @(posedge clk);
        @(negedge clk);
        check("R9 pulse width", tick_o, 0);
        find_tick(100, n);
        check("R5 period D=5", n + 1, 5);
        find_tick(100, n);
        check("R5 period again", n, 5);
    endtask

    task automatic t_reload300();
        int n;
        set_div(300);
        find_tick(1000, n);
        check("R4 first tick D=300", n, 300);
    endtask

    task automatic t_prescale();
        int n;
        prescale_sel_i = 1'b1;
        set_div(3);
        find_tick(200, n);
        check("R6 first tick 4*3", n, 12);
        find_tick(200, n);
        check("R6 period 4*3", n, 12);
        @(posedge clk);
        @(negedge clk);
        check("R9 width prescaled", tick_o, 0);
        prescale_sel_i = 1'b0;
    endtask

    task automatic t_div1();
        int hits = 0;
        prescale_sel_i = 1'b0;
        set_div(1);
        for (int k = 0; k < 10; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (tick_o) hits++;
        end
        check("R8 tick every cycle", hits, 10);
    endtask

    task automatic t_zero();
        int n;
        set_div(0);
        find_tick(500, n);
        check("R7 no tick with zero", n, 0);
    endtask

    task automatic t_max();
        int n;
        set_div(65535);
        find_tick(70000, n);
        check("R10 first tick D=65535", n, 65535);
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_write_read();
        t_locked();
        t_period5();
        t_reload300();
        t_prescale();
        t_div1();
        t_zero();
        t_max();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule